// File: doc/BRIEF.md
# Programmable Frame and Bit-Clock Generator

This block runs on a master clock and produces the timing for a chain of serial time-division-multiplexed codec devices. It drives a serial shift clock, a frame-sync pulse and a one-cycle frame-start strobe for the slot logic that shifts data in and out. It is used only in the device that sources the clocks for the chain. The other devices receive the frame sync and shift clock as inputs and do not instantiate it.

The frame period is the product of three factors, M, N and P, and a fixed factor of 16. All three are loaded through one 8-bit timing register, and its top bit selects which field a write updates. The number of shift-clock cycles in a frame depends on the configured device count and on a transfer-mode input. Control mode gives two 16-bit slots per device, and continuous mode gives one. A change of mode therefore doubles or halves the shift-clock rate while the frame rate stays the same.

New settings are staged and take effect only at a frame boundary. A setting that cannot give a whole number of master-clock cycles per shift-clock half period is flagged and ignored. In that case the last valid timing stays in force.

Top module: `tdm_clkgen`

## Requirements
- R1: Reset defaults. While reset is high and in the first cycle after it, fs=1, sclk=1, frame_start=0 and cfg_err=0. The defaults are M=16, N=6, P=8 and a two-device control-mode timing, so the first full frame is 12288 master-clock cycles long.
- R2: The frame period, measured between frame_start pulses, is 16×M×N×P master-clock cycles. A field value of 0 stands for 2^width, so M=0 means 128, N=0 means 16 and P=0 means 8.
- R3: Each shift-clock period is 2H master-clock cycles: H cycles high followed by H cycles low, with H = M·N·P / (2·D·K). D is the device count and K is 2 when cont_mode=0 or 1 when cont_mode=1. A frame holds 16·D·K shift-clock periods.
- R4: fs is high for exactly one shift-clock period, the last one of each frame. frame_start is a one-cycle pulse in the first cycle of each frame, in the same cycle that fs falls and sclk rises.
- R5: With the same M, N, P and device count, setting cont_mode to 1 halves the number of shift-clock periods per frame and leaves the frame period unchanged.
- R6: A write with cfg_wdata[7]=1 loads M from cfg_wdata[6:0]. A write with cfg_wdata[7]=0 loads N from cfg_wdata[6:3] and P from cfg_wdata[2:0].
- R7: Changes to M, N, P, cont_mode or dev_count made during a frame do not alter that frame. They take effect from the next frame.
- R8: cfg_err rises one cycle after the staged settings become invalid. Settings are invalid when dev_count is 0 or above 16, or when H is not a whole number. While they are invalid, frames keep the last valid timing. cfg_err falls one cycle after the settings become valid again.
- R9: Device counts of 1 and 16 are both accepted, including the case H=1, where each shift-clock phase lasts a single master-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Timing-register write strobe |
| cfg_wdata | input | 8 | Timing-register write data (bit 7 selects the M field or the N/P fields) |
| cont_mode | input | 1 | 1 = continuous mode (one slot per device), 0 = control mode (two slots per device) |
| dev_count | input | 5 | Number of devices in the chain, 1 to 16 |
| sclk | output | 1 | Serial shift clock |
| fs | output | 1 | Frame sync, high during the last shift-clock period of each frame |
| frame_start | output | 1 | One-cycle strobe at the first cycle of each frame |
| cfg_err | output | 1 | Staged settings invalid; last valid timing retained |

## Verification
A wrong count in the half-period or bit counters shows up within one frame. It changes the spacing between frame_start pulses, the number of sclk rises per frame, or the number of cycles fs stays high, so each of these is measured frame by frame against values derived from M, N, P, the device count and the mode. An update applied too early corrupts the frame in which it was written, and that frame is measured directly. A wrong validity decision shows at cfg_err one cycle after the inputs change, and within the next frame as timing that was not kept.

// File: rtl/tdm_clkgen_pkg.sv
package tdm_clkgen_pkg;
  // Field widths fixed by the timing-register layout
  localparam int M_W = 7;
  localparam int N_W = 4;
  localparam int P_W = 3;
  localparam int WD_W = 8;
  localparam int SEL_BIT = 7;

  typedef logic [M_W-1:0] m_fld_t;
  typedef logic [N_W-1:0] n_fld_t;
  typedef logic [P_W-1:0] p_fld_t;
endpackage

// File: rtl/tdm_clkgen_cfg.sv
module tdm_clkgen_cfg
  import tdm_clkgen_pkg::*;
#(
  parameter int MAX_DEVS  = 16,
  parameter int SLOT_BITS = 16,
  parameter int DEF_M     = 16,
  parameter int DEF_N     = 6,
  parameter int DEF_P     = 8,
  parameter int DEV_W     = 5,
  parameter int PROD_W    = 17,
  parameter int FBITS_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [WD_W-1:0]    cfg_wdata,
  input  logic               cont_mode,
  input  logic [DEV_W-1:0]   dev_count,
  output logic [PROD_W-1:0]  nxt_half,
  output logic [FBITS_W-1:0] nxt_bits,
  output logic               nxt_ok,
  output logic               cfg_err
);
  m_fld_t m_fld;
  n_fld_t n_fld;
  p_fld_t p_fld;

  // Staged fields; a zero field encodes 2^width
  always_ff @(posedge clk) begin
    if (rst) begin
      m_fld <= M_W'(DEF_M % (1 << M_W));
      n_fld <= N_W'(DEF_N % (1 << N_W));
      p_fld <= P_W'(DEF_P % (1 << P_W));
    end else if (cfg_wr) begin
      if (cfg_wdata[SEL_BIT]) begin
        m_fld <= cfg_wdata[M_W-1:0];
      end else begin
        n_fld <= cfg_wdata[P_W+N_W-1:P_W];
        p_fld <= cfg_wdata[P_W-1:0];
      end
    end
  end

  logic [M_W:0] m_val;
  logic [N_W:0] n_val;
  logic [P_W:0] p_val;
  assign m_val = (m_fld == '0) ? {1'b1, {M_W{1'b0}}} : {1'b0, m_fld};
  assign n_val = (n_fld == '0) ? {1'b1, {N_W{1'b0}}} : {1'b0, n_fld};
  assign p_val = (p_fld == '0) ? {1'b1, {P_W{1'b0}}} : {1'b0, p_fld};

  logic [PROD_W-1:0] prod, div_safe, rem;
  logic [DEV_W+1:0]  div_raw;
  logic              dev_ok;

  assign prod     = PROD_W'(m_val) * PROD_W'(n_val) * PROD_W'(p_val);
  // 2 * devices * slots-per-device
  assign div_raw  = cont_mode ? {1'b0, dev_count, 1'b0} : {dev_count, 2'b00};
  assign dev_ok   = (dev_count != '0) && (dev_count <= DEV_W'(MAX_DEVS));
  assign div_safe = dev_ok ? PROD_W'(div_raw) : PROD_W'(1);
  assign nxt_half = prod / div_safe;
  assign rem      = prod % div_safe;
  assign nxt_ok   = dev_ok && (rem == '0);
  assign nxt_bits = FBITS_W'(SLOT_BITS) * FBITS_W'(dev_count)
                  * (cont_mode ? FBITS_W'(1) : FBITS_W'(2));

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= !nxt_ok;
  end

  AST_ZERO_DEVS_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (dev_count == '0) |=> cfg_err); // R8
endmodule

// File: rtl/tdm_clkgen_timer.sv
module tdm_clkgen_timer #(
  parameter int HALF_W   = 17,
  parameter int FBITS_W  = 10,
  parameter int RST_HALF = 96,
  parameter int RST_BITS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HALF_W-1:0]  nxt_half,
  input  logic [FBITS_W-1:0] nxt_bits,
  input  logic               nxt_ok,
  output logic               sclk,
  output logic               fs,
  output logic               frame_start
);
  logic [HALF_W-1:0]  act_half, hcnt;
  logic [FBITS_W-1:0] act_bits, bcnt;
  logic               half_end, bit_end, frame_end;

  assign half_end  = (hcnt == act_half - 1'b1);
  assign bit_end   = half_end && !sclk;
  assign frame_end = bit_end && (bcnt == '0);

  // bcnt counts down the bits left; bit 0 is the sync bit
  always_ff @(posedge clk) begin
    if (rst) begin
      act_half    <= HALF_W'(RST_HALF);
      act_bits    <= FBITS_W'(RST_BITS);
      hcnt        <= '0;
      bcnt        <= '0;
      sclk        <= 1'b1;
      fs          <= 1'b1;
      frame_start <= 1'b0;
    end else begin
      frame_start <= frame_end;
      if (half_end) begin
        hcnt <= '0;
        sclk <= !sclk;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
      if (frame_end) begin
        fs <= 1'b0;
        if (nxt_ok) begin
          act_half <= nxt_half;
          act_bits <= nxt_bits;
          bcnt     <= nxt_bits - 1'b1;
        end else begin
          bcnt     <= act_bits - 1'b1;
        end
      end else if (bit_end) begin
        bcnt <= bcnt - 1'b1;
        fs   <= (bcnt == FBITS_W'(1));
      end
    end
  end

  AST_FS_DROPS_AT_START: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $fell(fs)); // R4
  AST_FS_DROP_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    $fell(fs) |-> frame_start); // R4
  AST_SCLK_RISES_AT_START: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $rose(sclk)); // R3
  AST_TIMING_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_half) |-> frame_start); // R7
  AST_HALF_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    hcnt < act_half); // R3
endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
  import tdm_clkgen_pkg::*;
#(
  parameter int MAX_DEVS  = 16,
  parameter int SLOT_BITS = 16,
  parameter int DEF_M     = 16,
  parameter int DEF_N     = 6,
  parameter int DEF_P     = 8,
  parameter int DEF_DEVS  = 2,
  parameter int DEV_W     = $clog2(MAX_DEVS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [WD_W-1:0]  cfg_wdata,
  input  logic             cont_mode,
  input  logic [DEV_W-1:0] dev_count,
  output logic             sclk,
  output logic             fs,
  output logic             frame_start,
  output logic             cfg_err
);
  localparam int PROD_W   = M_W + N_W + P_W + 3;
  localparam int FBITS_W  = $clog2(SLOT_BITS * MAX_DEVS * 2 + 1);
  localparam int DEF_HALF = (DEF_M * DEF_N * DEF_P) / (4 * DEF_DEVS);
  localparam int DEF_BITS = SLOT_BITS * DEF_DEVS * 2;

  logic [PROD_W-1:0]  nxt_half;
  logic [FBITS_W-1:0] nxt_bits;
  logic               nxt_ok;

  tdm_clkgen_cfg #(
    .MAX_DEVS(MAX_DEVS), .SLOT_BITS(SLOT_BITS),
    .DEF_M(DEF_M), .DEF_N(DEF_N), .DEF_P(DEF_P),
    .DEV_W(DEV_W), .PROD_W(PROD_W), .FBITS_W(FBITS_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cont_mode(cont_mode), .dev_count(dev_count),
    .nxt_half(nxt_half), .nxt_bits(nxt_bits), .nxt_ok(nxt_ok),
    .cfg_err(cfg_err)
  );

  tdm_clkgen_timer #(
    .HALF_W(PROD_W), .FBITS_W(FBITS_W),
    .RST_HALF(DEF_HALF), .RST_BITS(DEF_BITS)
  ) u_timer (
    .clk(clk), .rst(rst),
    .nxt_half(nxt_half), .nxt_bits(nxt_bits), .nxt_ok(nxt_ok),
    .sclk(sclk), .fs(fs), .frame_start(frame_start)
  );
endmodule

// File: tb/tdm_clkgen_tb.sv
module tdm_clkgen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       cont_mode = 1'b0;
  logic [4:0] dev_count = 5'd2;
  logic       sclk, fs, frame_start, cfg_err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tdm_clkgen u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cont_mode(cont_mode), .dev_count(dev_count),
    .sclk(sclk), .fs(fs), .frame_start(frame_start), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Measures one frame from a frame_start to the next; optional writes early in it
  task automatic frame_chk(input string req, input int e_len, input int e_bits, input int e_fs,
                           input int nwr = 0, input logic [7:0] w0 = 8'h00,
                           input logic [7:0] w1 = 8'h00);
    int len, rises, fsc;
    logic prev;
    while (!frame_start) @(negedge clk);
    chk("R4", "sclk high at frame start", int'(sclk), 1);
    chk("R4", "fs low at frame start", int'(fs), 0);
    len = 0; rises = 0; fsc = 0; prev = sclk;
    do begin
      if (nwr > 0 && len == 3) begin cfg_wr = 1'b1; cfg_wdata = w0; end
      else if (nwr > 1 && len == 4) begin cfg_wr = 1'b1; cfg_wdata = w1; end
      else cfg_wr = 1'b0;
      @(negedge clk);
      len++;
      if (sclk && !prev) rises++;
      if (fs) fsc++;
      prev = sclk;
    end while (!frame_start);
    cfg_wr = 1'b0;
    chk(req, "frame length", len, e_len);
    chk(req, "sclk periods per frame", rises, e_bits);
    chk(req, "fs high cycles", fsc, e_fs);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "fs in reset", int'(fs), 1);
    chk("R1", "frame_start in reset", int'(frame_start), 0);
    rst = 1'b0;
    chk("R1", "fs after reset", int'(fs), 1);
    chk("R1", "sclk after reset", int'(sclk), 1);
    chk("R1", "frame_start after reset", int'(frame_start), 0);
    chk("R1", "cfg_err after reset", int'(cfg_err), 0);
    frame_chk("R1", 12288, 64, 192);
  endtask

  task automatic t_cont_default;
    cont_mode = 1'b1;                    // at a frame_start, applies next frame
    frame_chk("R7", 12288, 64, 192);
    frame_chk("R5", 12288, 32, 384);
  endtask

  task automatic t_write_decode;
    // M=20 via 0x94; N=5,P=2 via 0x2A; written inside the frame
    frame_chk("R7", 12288, 32, 384, 2, 8'h94, 8'h2A);
    frame_chk("R6", 3200, 32, 100);
  endtask

  task automatic t_mode_switch;
    cont_mode = 1'b0;
    frame_chk("R7", 3200, 32, 100);
    frame_chk("R5", 3200, 64, 50);
  endtask

  task automatic t_invalid;
    dev_count = 5'd3;                    // 200/12 is not whole
    @(negedge clk);
    chk("R8", "cfg_err for 3 devices", int'(cfg_err), 1);
    frame_chk("R8", 3200, 64, 50);
    frame_chk("R8", 3200, 64, 50);
    dev_count = 5'd0;
    @(negedge clk);
    chk("R8", "cfg_err for 0 devices", int'(cfg_err), 1);
    dev_count = 5'd17;
    @(negedge clk);
    chk("R8", "cfg_err for 17 devices", int'(cfg_err), 1);
    frame_chk("R8", 3200, 64, 50);
    dev_count = 5'd4;
    cont_mode = 1'b1;                    // 200/8 = 25
    @(negedge clk);
    chk("R8", "cfg_err cleared", int'(cfg_err), 0);
    frame_chk("R8", 3200, 64, 50);
  endtask

  task automatic t_range;
    dev_count = 5'd1;                    // cont, H=100, 16 bits
    @(negedge clk);
    frame_chk("R9", 3200, 16, 200);
    dev_count = 5'd16;
    cont_mode = 1'b0;
    cfg_wr = 1'b1; cfg_wdata = 8'h84;    // M=4
    @(negedge clk);
    cfg_wdata = 8'h10;                   // N=2, P=0 -> 8
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    chk("R9", "cfg_err for 16 devices", int'(cfg_err), 0);
    frame_chk("R9", 1024, 512, 2);
  endtask

  task automatic t_zero_fields;
    dev_count = 5'd1;
    cont_mode = 1'b1;
    cfg_wr = 1'b1; cfg_wdata = 8'h81;    // M=1
    @(negedge clk);
    cfg_wdata = 8'h00;                   // N=16, P=8
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    frame_chk("R2", 2048, 16, 128);
    dev_count = 5'd2;
    cfg_wr = 1'b1; cfg_wdata = 8'h80;    // M=128
    @(negedge clk);
    cfg_wdata = 8'h09;                   // N=1, P=1
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    frame_chk("R2", 2048, 32, 64);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cont_default();
    t_write_decode();
    t_mode_switch();
    t_invalid();
    t_range();
    t_zero_fields();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule